// File: doc/BRIEF.md
# Packet Header Parcel Splitter

The splitter takes packets as a byte stream, one byte per beat, and divides each packet into a parcel and a tail. The parcel is a header container sent to a lookup engine. The tail is sent to a payload buffer memory. Packets arrive already checked. Header parsing, lookup and the memory controller sit outside this block.

A packet no longer than `WHOLE_MAX` bytes (320 by default) travels whole in the parcel. A longer packet gives only its first `HEAD_BYTES` bytes (256 by default) to the parcel, and every remaining byte goes to the tail stream. The block collects up to `WHOLE_MAX+1` bytes in a staging store before it decides which case applies.

Each parcel is released only after the packet's final byte has been seen. It carries a sideband header with:
- the preliminary traffic class,
- the total length,
- a tail-present flag,
- a buffer handle naming the tail.

Packets are processed one at a time, so parcels leave in arrival order. A packet that ends with its error flag set produces no parcel and does not use up a handle.

Top module: `hdr_parcel_split`

## Requirements
- R1: A packet of length L ≤ WHOLE_MAX yields one parcel of exactly L beats carrying its bytes in order, and no tail beats. `parcel_sop_o` is high only on the first beat and `parcel_last_o` only on the final beat.
- R2: A packet of length L > WHOLE_MAX yields a parcel of exactly HEAD_BYTES beats (bytes 0..HEAD_BYTES-1). It also yields L-HEAD_BYTES tail beats carrying bytes HEAD_BYTES..L-1 in order, with `tail_last_o` high only on the final tail beat.
- R3: While a parcel is presented, `parcel_len_o` equals the packet's total byte count. `parcel_tail_o` is 1 exactly when that count exceeds WHOLE_MAX.
- R4: The class on `in_cls_i` is sampled with the first byte of a packet and held in `parcel_cls_o`. The encodings are 0 best-effort, 1 real-time and 2 control; the reserved code 3 is forwarded as 0.
- R5: Every tail beat of a packet and that packet's parcel carry the same handle. After reset the handle is 0. It advances by one (modulo 2^HANDLE_W) only when the parcel of an error-free long packet completes.
- R6: A packet whose final byte has `in_err_i` high produces no parcel and leaves the handle unchanged. If it is long, its final tail beat has `tail_abort_o` high; otherwise `tail_abort_o` stays low.
- R7: While `parcel_valid_o` or `tail_valid_o` is high and the matching ready is low, that output holds its data, flags and header stable. The input stalls and no byte is lost or reordered.
- R8: After reset `parcel_valid_o` and `tail_valid_o` are low, `in_ready_o` is high and the handle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Final byte of packet |
| in_err_i | input | 1 | Packet bad; meaningful with in_last_i |
| in_cls_i | input | 2 | Preliminary class, sampled on first byte |
| parcel_valid_o | output | 1 | Parcel beat valid |
| parcel_ready_i | input | 1 | Lookup side accepts beat |
| parcel_data_o | output | 8 | Parcel byte |
| parcel_sop_o | output | 1 | First parcel beat |
| parcel_last_o | output | 1 | Final parcel beat |
| parcel_cls_o | output | 2 | Header: class |
| parcel_len_o | output | LEN_W | Header: total packet length |
| parcel_tail_o | output | 1 | Header: tail present |
| parcel_handle_o | output | HANDLE_W | Header: tail buffer handle |
| tail_valid_o | output | 1 | Tail beat valid |
| tail_ready_i | input | 1 | Buffer memory accepts beat |
| tail_data_o | output | 8 | Tail byte |
| tail_last_o | output | 1 | Final tail beat |
| tail_abort_o | output | 1 | Tail of a bad packet, discard |
| tail_handle_o | output | HANDLE_W | Handle for tail bytes |

## Verification
The hardest cases lie at the split threshold. One is a packet of exactly WHOLE_MAX+1 bytes: its final byte is the one that forces the long decision, so the tail drains entirely from the staging store and never passes straight through. The other is an error on the final byte of a long packet, after tail bytes have already gone out. The bench uses a small configuration (HEAD_BYTES=8, WHOLE_MAX=12, HANDLE_W=3). It sweeps every length from 1 to 22, with and without the error flag, and with and without periodic back-pressure on both outputs. This covers both threshold lengths, handle wrap-around and handle reuse after a dropped packet.

// File: rtl/hdr_parcel_split_pkg.sv
package hdr_parcel_split_pkg;

  typedef enum logic [1:0] {
    CLS_BE   = 2'd0,
    CLS_RT   = 2'd1,
    CLS_CTRL = 2'd2
  } pre_cls_e;

  typedef enum logic [1:0] {
    ST_FILL,
    ST_DRAIN,
    ST_PASS,
    ST_SEND
  } split_st_e;

  function automatic logic [1:0] map_cls(input logic [1:0] raw);
    return (raw == 2'd3) ? CLS_BE : raw;
  endfunction

endpackage

// File: rtl/hdr_parcel_stage_mem.sv
module hdr_parcel_stage_mem #(
  parameter int DEPTH = 321,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/hdr_parcel_handle_ctr.sv
module hdr_parcel_handle_ctr #(
  parameter int HANDLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  output logic [HANDLE_W-1:0] handle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    handle_o <= '0;
    else if (adv_i) handle_o <= handle_o + HANDLE_W'(1);
  end
endmodule

// File: rtl/hdr_parcel_split.sv
module hdr_parcel_split
  import hdr_parcel_split_pkg::*;
#(
  parameter int HEAD_BYTES = 256,
  parameter int WHOLE_MAX  = 320,
  parameter int LEN_W      = 16,
  parameter int HANDLE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [7:0]          in_data_i,
  input  logic                in_last_i,
  input  logic                in_err_i,
  input  logic [1:0]          in_cls_i,
  output logic                parcel_valid_o,
  input  logic                parcel_ready_i,
  output logic [7:0]          parcel_data_o,
  output logic                parcel_sop_o,
  output logic                parcel_last_o,
  output logic [1:0]          parcel_cls_o,
  output logic [LEN_W-1:0]    parcel_len_o,
  output logic                parcel_tail_o,
  output logic [HANDLE_W-1:0] parcel_handle_o,
  output logic                tail_valid_o,
  input  logic                tail_ready_i,
  output logic [7:0]          tail_data_o,
  output logic                tail_last_o,
  output logic                tail_abort_o,
  output logic [HANDLE_W-1:0] tail_handle_o
);
  localparam int DEPTH = WHOLE_MAX + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(WHOLE_MAX);
  localparam logic [AW-1:0] HEAD_IDX = AW'(HEAD_BYTES);
  localparam logic [AW-1:0] HEAD_END = AW'(HEAD_BYTES - 1);

  split_st_e          st_q;
  logic [AW-1:0]      wr_q, rd_q, send_end;
  logic [LEN_W-1:0]   len_q;
  logic [1:0]         cls_q;
  logic               long_q, ended_q, err_q;
  logic [7:0]         rd_data;
  logic               in_fire, tail_fire, parcel_fire, handle_adv;
  logic [HANDLE_W-1:0] handle;

  hdr_parcel_stage_mem #(.DEPTH(DEPTH), .AW(AW)) u_stage (
    .clk_i   (clk_i),
    .we_i    (st_q == ST_FILL && in_valid_i),
    .waddr_i (wr_q),
    .wdata_i (in_data_i),
    .raddr_i (rd_q),
    .rdata_o (rd_data)
  );

  hdr_parcel_handle_ctr #(.HANDLE_W(HANDLE_W)) u_handle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (handle_adv),
    .handle_o (handle)
  );

  assign send_end = long_q ? HEAD_END : AW'(len_q - LEN_W'(1));

  always_comb begin
    in_ready_o     = 1'b0;
    tail_valid_o   = 1'b0;
    tail_data_o    = rd_data;
    tail_last_o    = 1'b0;
    tail_abort_o   = 1'b0;
    parcel_valid_o = 1'b0;
    unique case (st_q)
      ST_FILL:  in_ready_o = 1'b1;
      ST_DRAIN: begin
        tail_valid_o = 1'b1;
        tail_last_o  = ended_q && (rd_q == LAST_IDX);
        tail_abort_o = ended_q && err_q && (rd_q == LAST_IDX);
      end
      ST_PASS: begin
        in_ready_o   = tail_ready_i;
        tail_valid_o = in_valid_i;
        tail_data_o  = in_data_i;
        tail_last_o  = in_last_i;
        tail_abort_o = in_last_i && in_err_i;
      end
      ST_SEND:  parcel_valid_o = 1'b1;
      default: ;
    endcase
  end

  assign in_fire     = in_valid_i && in_ready_o;
  assign tail_fire   = tail_valid_o && tail_ready_i;
  assign parcel_fire = parcel_valid_o && parcel_ready_i;
  assign handle_adv  = parcel_fire && parcel_last_o && long_q;

  assign parcel_data_o   = rd_data;
  assign parcel_sop_o    = (rd_q == '0);
  assign parcel_last_o   = (rd_q == send_end);
  assign parcel_cls_o    = cls_q;
  assign parcel_len_o    = len_q;
  assign parcel_tail_o   = long_q;
  assign parcel_handle_o = handle;
  assign tail_handle_o   = handle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FILL;
      wr_q    <= '0;
      rd_q    <= '0;
      len_q   <= '0;
      cls_q   <= CLS_BE;
      long_q  <= 1'b0;
      ended_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_FILL: if (in_fire) begin
          len_q <= len_q + LEN_W'(1);
          if (wr_q == '0) cls_q <= map_cls(in_cls_i);
          if (wr_q == LAST_IDX) begin
            // threshold crossed: bytes past the head go to the tail
            long_q  <= 1'b1;
            ended_q <= in_last_i;
            err_q   <= in_err_i;
            rd_q    <= HEAD_IDX;
            st_q    <= ST_DRAIN;
          end else if (in_last_i && in_err_i) begin
            wr_q  <= '0;
            len_q <= '0;
          end else if (in_last_i) begin
            rd_q <= '0;
            st_q <= ST_SEND;
          end else begin
            wr_q <= wr_q + AW'(1);
          end
        end
        ST_DRAIN: if (tail_fire) begin
          if (rd_q != LAST_IDX) rd_q <= rd_q + AW'(1);
          else if (!ended_q) st_q <= ST_PASS;
          else if (err_q) begin
            wr_q   <= '0;
            len_q  <= '0;
            long_q <= 1'b0;
            st_q   <= ST_FILL;
          end else begin
            rd_q <= '0;
            st_q <= ST_SEND;
          end
        end
        ST_PASS: if (in_fire) begin
          len_q <= len_q + LEN_W'(1);
          if (in_last_i && in_err_i) begin
            wr_q   <= '0;
            len_q  <= '0;
            long_q <= 1'b0;
            st_q   <= ST_FILL;
          end else if (in_last_i) begin
            rd_q <= '0;
            st_q <= ST_SEND;
          end
        end
        ST_SEND: if (parcel_fire) begin
          if (parcel_last_o) begin
            wr_q   <= '0;
            rd_q   <= '0;
            len_q  <= '0;
            long_q <= 1'b0;
            st_q   <= ST_FILL;
          end else begin
            rd_q <= rd_q + AW'(1);
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/hdr_parcel_split_chk.sv
module hdr_parcel_split_chk #(
  parameter int HEAD_BYTES = 256,
  parameter int WHOLE_MAX  = 320,
  parameter int LEN_W      = 16,
  parameter int HANDLE_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                parcel_valid_o,
  input logic                parcel_ready_i,
  input logic [7:0]          parcel_data_o,
  input logic                parcel_sop_o,
  input logic                parcel_last_o,
  input logic [1:0]          parcel_cls_o,
  input logic [LEN_W-1:0]    parcel_len_o,
  input logic                parcel_tail_o,
  input logic [HANDLE_W-1:0] parcel_handle_o,
  input logic                tail_valid_o,
  input logic                tail_ready_i,
  input logic [7:0]          tail_data_o,
  input logic                tail_last_o,
  input logic [HANDLE_W-1:0] tail_handle_o
);
  logic [LEN_W-1:0] beats_q;
  logic             pfire;

  assign pfire = parcel_valid_o && parcel_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beats_q <= '0;
    else if (pfire)  beats_q <= parcel_last_o ? '0 : beats_q + LEN_W'(1);
  end

  a_r7_parcel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parcel_valid_o && !parcel_ready_i |=> parcel_valid_o && $stable(parcel_data_o)
      && $stable(parcel_sop_o) && $stable(parcel_last_o) && $stable(parcel_len_o)
      && $stable(parcel_cls_o) && $stable(parcel_handle_o));

  a_r7_tail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_valid_o && !tail_ready_i |=> tail_valid_o && $stable(tail_data_o)
      && $stable(tail_last_o) && $stable(tail_handle_o));

  a_r3_tail_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parcel_valid_o |-> parcel_tail_o == (int'(parcel_len_o) > WHOLE_MAX));

  a_r4_cls_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parcel_valid_o |-> parcel_cls_o != 2'd3);

  a_r1_one_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(parcel_valid_o && tail_valid_o));

  a_r2_parcel_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfire && parcel_last_o |->
      (int'(beats_q) + 1) == (parcel_tail_o ? HEAD_BYTES : int'(parcel_len_o)));

  a_r1_sop_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parcel_valid_o |-> parcel_sop_o == (beats_q == '0));

  a_r5_handle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfire && parcel_last_o && parcel_tail_o |=>
      parcel_handle_o == $past(parcel_handle_o) + HANDLE_W'(1));
endmodule

bind hdr_parcel_split hdr_parcel_split_chk #(
  .HEAD_BYTES(HEAD_BYTES), .WHOLE_MAX(WHOLE_MAX), .LEN_W(LEN_W), .HANDLE_W(HANDLE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .parcel_valid_o(parcel_valid_o), .parcel_ready_i(parcel_ready_i),
  .parcel_data_o(parcel_data_o), .parcel_sop_o(parcel_sop_o),
  .parcel_last_o(parcel_last_o), .parcel_cls_o(parcel_cls_o),
  .parcel_len_o(parcel_len_o), .parcel_tail_o(parcel_tail_o),
  .parcel_handle_o(parcel_handle_o),
  .tail_valid_o(tail_valid_o), .tail_ready_i(tail_ready_i),
  .tail_data_o(tail_data_o), .tail_last_o(tail_last_o),
  .tail_handle_o(tail_handle_o)
);

// File: tb/hdr_parcel_split_test.sv
module hdr_parcel_split_test;
  localparam int HB = 8;
  localparam int WM = 12;
  localparam int LW = 16;
  localparam int HW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_cls = '0;
  logic in_ready;
  logic p_valid, p_ready, p_sop, p_last, p_tail;
  logic [7:0] p_data;
  logic [1:0] p_cls;
  logic [LW-1:0] p_len;
  logic [HW-1:0] p_handle;
  logic t_valid, t_ready, t_last, t_abort;
  logic [7:0] t_data;
  logic [HW-1:0] t_handle;

  always #4 clk = ~clk;

  hdr_parcel_split #(.HEAD_BYTES(HB), .WHOLE_MAX(WM), .LEN_W(LW), .HANDLE_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_last_i(in_last), .in_err_i(in_err), .in_cls_i(in_cls),
    .parcel_valid_o(p_valid), .parcel_ready_i(p_ready), .parcel_data_o(p_data),
    .parcel_sop_o(p_sop), .parcel_last_o(p_last), .parcel_cls_o(p_cls),
    .parcel_len_o(p_len), .parcel_tail_o(p_tail), .parcel_handle_o(p_handle),
    .tail_valid_o(t_valid), .tail_ready_i(t_ready), .tail_data_o(t_data),
    .tail_last_o(t_last), .tail_abort_o(t_abort), .tail_handle_o(t_handle)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit bp = 1'b0, running = 1'b0;

  logic [7:0] pbuf [64];
  logic [7:0] tbuf [64];
  int pn, tn, t_lastpos;
  bit p_done, p_flag_bad, t_abort_seen, t_abort_bad;
  logic [1:0] h_cls;
  logic [LW-1:0] h_len;
  logic h_tail;
  logic [HW-1:0] h_handle, t_handle0;
  bit t_handle_bad;

  function automatic logic [7:0] pat(int pid, int i);
    return 8'(pid * 13 + i * 3 + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    p_ready <= bp ? (cyc % 3 != 1) : 1'b1;
    t_ready <= bp ? (cyc % 4 != 2) : 1'b1;
    #1;
    if (running && p_valid && p_ready) begin
      if (p_done || (p_sop != (pn == 0))) p_flag_bad = 1'b1;
      if (pn == 0) begin
        h_cls = p_cls; h_len = p_len; h_tail = p_tail; h_handle = p_handle;
      end
      if (pn < 64) pbuf[pn] = p_data;
      pn++;
      if (p_last) p_done = 1'b1;
    end
    if (running && t_valid && t_ready) begin
      if (tn == 0) t_handle0 = t_handle;
      else if (t_handle != t_handle0) t_handle_bad = 1'b1;
      if (tn < 64) tbuf[tn] = t_data;
      if (t_last) t_lastpos = tn;
      if (t_abort) begin
        t_abort_seen = 1'b1;
        if (!t_last) t_abort_bad = 1'b1;
      end
      tn++;
    end
  end

  initial begin
    p_ready = 1'b1;
    t_ready = 1'b1;
  end

  logic [HW-1:0] h_exp = '0;

  task automatic send_pkt(int pid, int len, int cls, bit err);
    int exp_pn, exp_tn, bad;
    logic [1:0] exp_cls;
    bit long_p;
    long_p = len > WM;
    exp_pn = err ? 0 : (long_p ? HB : len);
    exp_tn = long_p ? len - HB : 0;
    exp_cls = (cls == 3) ? 2'd0 : 2'(cls);
    pn = 0; tn = 0; t_lastpos = -1; p_done = 0; p_flag_bad = 0;
    t_abort_seen = 0; t_abort_bad = 0; t_handle_bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(pid, i); in_last = (i == len - 1);
      in_err = err && (i == len - 1); in_cls = (i == 0) ? 2'(cls) : 2'(~cls);
      #2;
      while (!in_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    for (int k = 0; k < 80 && !p_done; k++) @(negedge clk);
    repeat (3) @(negedge clk);

    if (err) begin
      chk(pn == 0, "R6", $sformatf("parcel beats for bad pkt len=%0d", len), pn, 0);
      chk(t_abort_seen == long_p && !t_abort_bad, "R6", $sformatf("abort flag len=%0d", len),
          int'(t_abort_seen), int'(long_p));
    end else begin
      bad = 0;
      for (int i = 0; i < exp_pn && i < pn; i++) if (pbuf[i] != pat(pid, i)) bad++;
      chk(pn == exp_pn && p_done && !p_flag_bad && bad == 0, long_p ? "R2" : "R1",
          $sformatf("parcel beats/bytes len=%0d bp=%0d errs=%0d", len, bp, bad), pn, exp_pn);
      chk(h_len == LW'(len) && h_tail == long_p, "R3",
          $sformatf("hdr len/tail len=%0d tail=%0d", len, h_tail), int'(h_len), len);
      chk(h_cls == exp_cls, "R4", "class", int'(h_cls), int'(exp_cls));
      chk(h_handle == h_exp, "R5", "parcel handle", int'(h_handle), int'(h_exp));
      chk(!t_abort_seen, "R6", "abort on good pkt", int'(t_abort_seen), 0);
    end
    bad = 0;
    for (int i = 0; i < exp_tn && i < tn; i++) if (tbuf[i] != pat(pid, HB + i)) bad++;
    chk(tn == exp_tn && bad == 0 && (exp_tn == 0 || t_lastpos == exp_tn - 1),
        long_p ? "R2" : "R1", $sformatf("tail beats/bytes len=%0d bp=%0d errs=%0d", len, bp, bad),
        tn, exp_tn);
    if (long_p)
      chk(!t_handle_bad && t_handle0 == h_exp, "R5", "tail handle", int'(t_handle0), int'(h_exp));
    if (bp) chk(pn == exp_pn && tn == exp_tn, "R7", "no loss under back-pressure", pn + tn, exp_pn + exp_tn);
    if (long_p && !err) h_exp = h_exp + HW'(1);
  endtask

  initial begin
    int pid;
    repeat (3) @(negedge clk);
    chk(!p_valid && !t_valid, "R8", "valids in reset", int'(p_valid) + int'(t_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(in_ready && !p_valid && !t_valid, "R8", "idle after reset", int'(in_ready), 1);
    chk(p_handle == '0, "R8", "handle after reset", int'(p_handle), 0);
    running = 1'b1;
    pid = 0;
    for (int b = 0; b < 2; b++) begin
      bp = b[0];
      for (int e = 0; e < 2; e++)
        for (int len = 1; len <= 22; len++) begin
          send_pkt(pid, len, len % 4, e[0]);
          pid++;
        end
    end
    // R6: handle reused after a dropped long packet
    send_pkt(pid, 17, 1, 1'b1); pid++;
    send_pkt(pid, 16, 2, 1'b0); pid++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule